// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three complementary pairs of gate signals for a three-phase inverter bridge. A 16-bit counter runs up, then down, at the processor cycle rate. Each phase compares the counter against its own duty value, which gives high-side pulses centred on the middle of every switching period. Each pair then gets a programmable dead time inserted between its complementary edges. Pulses too narrow for the power stage are removed at the moment a duty value is loaded. A duty value equal to or above the half-period holds the high side on for the whole period.

Software programs the block through a simple write port. The settings are the half-period, three duty values, dead time, minimum pulse width, sync pulse width, chopping divider and a control word. Duty values are loaded once per period, or also at the period midpoint when double update is selected. A static input pin selects the output polarity. A high-frequency chopping carrier can be gated onto the high-side outputs, the low-side outputs, or both. An active-low trip input turns all six gates off at once, without waiting for a clock. The trip stays latched until software clears it while the trip input is high.

Register map (write port `wr_addr`): 0 half-period P, 1/2/3 duty of phases A/B/C, 4 dead time (10 bits), 5 minimum pulse width (10 bits), 6 sync width W (8 bits), 7 chop divider N (8 bits), 8 control, 9 trip clear (any data). Control bits: bit 0 double update, bit 1 chop high sides, bit 2 chop low sides, bits 13:8 output enables in gate order. Gate order: bit 0 AH, 1 AL, 2 BH, 3 BL, 4 CH, 5 CL. Every register except the control word resets to 0, and the control word also resets to 0, so all outputs are disabled after reset.

Top module: `tri_pwm_gen`

## Requirements
- R1: The counter period is 2·P cycles, with P clamped to at least 2. `period_irq` is a one-cycle pulse on the first cycle of every period, so consecutive pulses are 2·P cycles apart.
- R2: `pwm_sync` goes high on the same cycle as `period_irq` and stays high for W+1 cycles, where W is the sync width register.
- R3: With zero dead time, the high side of a phase with duty D (0 ≤ D ≤ P) is active for 2·D cycles per period, and the low side is active for the remaining 2·P−2·D cycles.
- R4: In single update mode (control bit 0 = 0), a duty written during a period takes effect only at the start of the next period.
- R5: In double update mode (control bit 0 = 1), a duty written in the first half of a period takes effect at the midpoint of that period.
- R6: Each edge of a pair is followed by a gap of 2·T cycles in which both gates of the pair are off, where T is the dead-time register. With duty D, the high side is active 2·D−2·T cycles per period and the low side 2·P−2·D−2·T cycles.
- R7: Let M be the minimum pulse width register. A duty with 2·D < M is loaded as 0 (high side never on). A duty with 2·(P−D) < M is loaded as P (high side always on). A duty with 2·D = M is kept unchanged.
- R8: A duty of P or more holds the high side active for the whole period and the low side never active, with no gap at the period boundary.
- R9: While `trip_n` is low, all six gates are in their off state immediately. After `trip_n` returns high, the gates stay off until a write to the trip-clear register is made while `trip_n` is high. A clear written while `trip_n` is low has no effect.
- R10: A gate whose enable bit in control bits 13:8 is 0 stays in its off state.
- R11: With `pol_hi` = 1, an active gate is driven high and an off gate low. With `pol_hi` = 0, both levels are inverted.
- R12: With chopping enabled for a side, the active gates of that side are ANDed with a carrier of period 4·(N+1) cycles and 50 % duty, where N is the chop divider register.
- R13: The two gates of one pair are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 16 | Register write data |
| trip_n | input | 1 | Asynchronous active-low trip |
| pol_hi | input | 1 | Static polarity select, 1 = active-high gates |
| gate | output | 6 | Gate drives {CL, CH, BL, BH, AL, AH} |
| pwm_sync | output | 1 | Period sync pulse, W+1 cycles wide |
| period_irq | output | 1 | One-cycle period-start interrupt |

## Verification
The hardest behaviour to reach from the ports is a duty change in the middle of a period, because it must land between two load points. The bench first aligns itself on `period_irq`. It then waits a fixed number of cycles so that the write falls early in the up-counting half. Next it counts high-side active cycles until the next period start, and that count shows whether the old or the new duty governed the second half. A second case sets `trip_n` low and writes a clear while it is still low, then releases it. This shows that the latch, not the pin, holds the gates off.

// File: rtl/tri_pwm_pkg.sv
// Shared register addresses and control-word layout for the three-phase
// PWM generator. Assumes a 4-bit register address.
package tri_pwm_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_HALF    = 4'd0,
        REG_DUTY_A  = 4'd1,
        REG_DUTY_B  = 4'd2,
        REG_DUTY_C  = 4'd3,
        REG_DEAD    = 4'd4,
        REG_MINPW   = 4'd5,
        REG_SYNCW   = 4'd6,
        REG_CHOP    = 4'd7,
        REG_CTRL    = 4'd8,
        REG_TRIPCLR = 4'd9
    } reg_addr_e;

    // Control word fields (bit 0 upward: dbl_upd, chop_hi, chop_lo, gap, out_en)
    typedef struct packed {
        logic [5:0] out_en;
        logic [4:0] unused;
        logic       chop_lo;
        logic       chop_hi;
        logic       dbl_upd;
    } ctrl_t;

endpackage

// File: rtl/pwm_timebase.sv
// Up/down period counter for center-aligned PWM.
// The counter runs 0..P-1 while counting up, then P-1..0 while counting down,
// which gives a period of 2*P cycles. It also raises the load strobes at the
// end of each half and produces the sync pulse and the period-start flag.
// Assumes the half-period register is sampled only at the period start.
module pwm_timebase #(
    parameter int CNT_W    = 16,
    parameter int SW_W     = 8,
    parameter int DEF_HALF = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_sh,
    input  logic [SW_W-1:0]  sync_w,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] half_act,
    output logic [CNT_W-1:0] next_half,
    output logic             ld_start,
    output logic             ld_mid,
    output logic             start,
    output logic             sync
);
    localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(2);
    localparam logic [CNT_W-1:0] DEF_CL   = (DEF_HALF < 2) ? MIN_HALF : CNT_W'(DEF_HALF);

    logic             dir_dn;
    logic [CNT_W-1:0] half_cl;
    logic [SW_W-1:0]  sync_rem;

    // Clamp the programmed half-period to the smallest workable value
    assign half_cl   = (half_sh < MIN_HALF) ? MIN_HALF : half_sh;
    // End-of-half strobes: last cycle of the down half and of the up half
    assign ld_start  = dir_dn && (cnt == '0);
    assign ld_mid    = !dir_dn && (cnt == half_act - 1'b1);
    assign start     = !dir_dn && (cnt == '0);
    assign next_half = ld_start ? half_cl : half_act;
    assign sync      = start || (sync_rem != '0);

    // Counter and direction, with the half-period reloaded at each period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_dn   <= 1'b0;
            half_act <= DEF_CL;
        end else if (ld_start) begin
            dir_dn   <= 1'b0;
            half_act <= half_cl;
        end else if (ld_mid) begin
            dir_dn   <= 1'b1;
        end else if (dir_dn) begin
            cnt      <= cnt - 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

    // Remaining sync cycles after the period-start cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_rem <= '0;
        end else if (start) begin
            sync_rem <= sync_w;
        end else if (sync_rem != '0) begin
            sync_rem <= sync_rem - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_phase.sv
// One phase leg: duty load with minimum-pulse deletion, center-aligned
// compare, and dead-time insertion on both complementary edges.
// Assumes the load strobe coincides with a half boundary of the counter and
// that next_half is the half-period in force after that boundary.
module pwm_phase #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10,
    parameter int MPW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half_act,
    input  logic [CNT_W-1:0] next_half,
    input  logic             load,
    input  logic [CNT_W-1:0] duty_sh,
    input  logic [DT_W-1:0]  dead,
    input  logic [MPW_W-1:0] minpw,
    output logic             hi_on,
    output logic             lo_on
);
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] duty_eff;
    logic [CNT_W-1:0] gap;
    logic [CNT_W:0]   two_d;
    logic [CNT_W:0]   two_gap;
    logic [CNT_W:0]   mpw_x;
    logic             raw;
    logic             prev_r;
    logic [DT_W:0]    dcnt;

    assign two_d   = {duty_sh, 1'b0};
    assign gap     = next_half - duty_sh;
    assign two_gap = {gap, 1'b0};
    assign mpw_x   = (CNT_W+1)'(minpw);

    // Effective duty: delete pulses narrower than the minimum width, clamp overmodulation
    always_comb begin
        if (two_d < mpw_x) begin
            duty_eff = '0;
        end else if (duty_sh >= next_half) begin
            duty_eff = next_half;
        end else if (two_gap < mpw_x) begin
            duty_eff = next_half;
        end else begin
            duty_eff = duty_sh;
        end
    end

    // Active duty register, updated only on a load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (load) begin
            duty_act <= duty_eff;
        end
    end

    // High-side request is on in the part of each half nearest the top of the count
    assign raw = (cnt >= (half_act - duty_act));

    // Edge tracking and dead-time countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_r <= 1'b0;
            dcnt   <= '0;
        end else if (raw != prev_r) begin
            prev_r <= raw;
            dcnt   <= {dead, 1'b0};
        end else if (dcnt != '0) begin
            dcnt   <= dcnt - 1'b1;
        end
    end

    assign hi_on = prev_r && (dcnt == '0);
    assign lo_on = !prev_r && (dcnt == '0);

endmodule

// File: rtl/pwm_outstage.sv
// Output stage: chopping carrier, per-gate enable, trip latch and polarity.
// The trip pin gates the outputs combinationally, so a trip turns them off
// without a clock. A two-stage synchronized copy of the pin sets the latch.
// Assumes even gate indices are high sides and odd indices low sides.
module pwm_outstage #(
    parameter int NG     = 6,
    parameter int CHOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NG-1:0]     pair_on,
    input  logic [NG-1:0]     out_en,
    input  logic              chop_hi,
    input  logic              chop_lo,
    input  logic [CHOP_W-1:0] chop_div,
    input  logic              trip_n,
    input  logic              trip_clr,
    input  logic              pol_hi,
    output logic [NG-1:0]     gate
);
    logic [CHOP_W:0] chop_cnt;
    logic [CHOP_W:0] chop_lim;
    logic            carrier;
    logic [1:0]      trip_s;
    logic            tripped;
    logic            allow;

    assign chop_lim = {chop_div, 1'b1};

    // Chop carrier toggles every 2*(N+1) cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chop_cnt <= '0;
            carrier  <= 1'b1;
        end else if (chop_cnt == chop_lim) begin
            chop_cnt <= '0;
            carrier  <= ~carrier;
        end else begin
            chop_cnt <= chop_cnt + 1'b1;
        end
    end

    // Synchronize the trip pin for the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_s <= 2'b11;
        end else begin
            trip_s <= {trip_s[0], trip_n};
        end
    end

    // Trip latch: set while the pin is low, cleared by a write while it is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tripped <= 1'b0;
        end else if (!trip_s[1]) begin
            tripped <= 1'b1;
        end else if (trip_clr) begin
            tripped <= 1'b0;
        end
    end

    assign allow = trip_n && !tripped;

    for (genvar k = 0; k < NG; k++) begin : g_gate
        logic chop_ok;
        if (k % 2 == 0) begin : g_hi
            assign chop_ok = !chop_hi || carrier;
        end else begin : g_lo
            assign chop_ok = !chop_lo || carrier;
        end
        assign gate[k] = (pair_on[k] && out_en[k] && chop_ok && allow) ^ ~pol_hi;
    end

endmodule

// File: rtl/tri_pwm_gen.sv
// Three-phase center-aligned PWM generator top level.
// Holds the programmable registers, the shared time base, one phase leg per
// phase and the output stage. Writes to duty and half-period registers land
// in shadow registers and are used only at the next load point.
module tri_pwm_gen
    import tri_pwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 10,
    parameter int MPW_W    = 10,
    parameter int SW_W     = 8,
    parameter int CHOP_W   = 8,
    parameter int NPH      = 3,
    parameter int DEF_HALF = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              trip_n,
    input  logic              pol_hi,
    output logic [2*NPH-1:0]  gate,
    output logic              pwm_sync,
    output logic              period_irq
);
    localparam int NG = 2 * NPH;

    logic [CNT_W-1:0]  half_sh;
    logic [CNT_W-1:0]  duty_sh [NPH];
    logic [DT_W-1:0]   dead_r;
    logic [MPW_W-1:0]  minpw_r;
    logic [SW_W-1:0]   syncw_r;
    logic [CHOP_W-1:0] chop_r;
    ctrl_t             ctrl_r;

    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  half_act_w;
    logic [CNT_W-1:0]  next_half_w;
    logic              ld_start_w;
    logic              ld_mid_w;
    logic              duty_load;
    logic [NG-1:0]     pair_on;
    logic              trip_clr;

    // Common register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_sh <= '0;
            dead_r  <= '0;
            minpw_r <= '0;
            syncw_r <= '0;
            chop_r  <= '0;
            ctrl_r  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_HALF:  half_sh <= wr_data;
                REG_DEAD:  dead_r  <= wr_data[DT_W-1:0];
                REG_MINPW: minpw_r <= wr_data[MPW_W-1:0];
                REG_SYNCW: syncw_r <= wr_data[SW_W-1:0];
                REG_CHOP:  chop_r  <= wr_data[CHOP_W-1:0];
                REG_CTRL:  ctrl_r  <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                default:   ;
            endcase
        end
    end

    assign trip_clr  = wr_en && (wr_addr == REG_TRIPCLR);
    assign duty_load = ld_start_w || (ctrl_r.dbl_upd && ld_mid_w);

    pwm_timebase #(
        .CNT_W    (CNT_W),
        .SW_W     (SW_W),
        .DEF_HALF (DEF_HALF)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_sh   (half_sh),
        .sync_w    (syncw_r),
        .cnt       (cnt_w),
        .half_act  (half_act_w),
        .next_half (next_half_w),
        .ld_start  (ld_start_w),
        .ld_mid    (ld_mid_w),
        .start     (period_irq),
        .sync      (pwm_sync)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        // Shadow duty register of this phase
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_sh[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(int'(REG_DUTY_A) + i))) begin
                duty_sh[i] <= wr_data;
            end
        end

        pwm_phase #(
            .CNT_W (CNT_W),
            .DT_W  (DT_W),
            .MPW_W (MPW_W)
        ) u_ph (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt_w),
            .half_act  (half_act_w),
            .next_half (next_half_w),
            .load      (duty_load),
            .duty_sh   (duty_sh[i]),
            .dead      (dead_r),
            .minpw     (minpw_r),
            .hi_on     (pair_on[2*i]),
            .lo_on     (pair_on[2*i+1])
        );
    end

    pwm_outstage #(
        .NG     (NG),
        .CHOP_W (CHOP_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_on  (pair_on),
        .out_en   (ctrl_r.out_en[NG-1:0]),
        .chop_hi  (ctrl_r.chop_hi),
        .chop_lo  (ctrl_r.chop_lo),
        .chop_div (chop_r),
        .trip_n   (trip_n),
        .trip_clr (trip_clr),
        .pol_hi   (pol_hi),
        .gate     (gate)
    );

endmodule

// File: rtl/tri_pwm_chk.sv
// Property checker for the three-phase PWM generator, bound to the top.
// Watches the gate pins, the period flags and the internal time base.
module tri_pwm_chk #(
    parameter int NPH   = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_n,
    input logic             pol_hi,
    input logic [2*NPH-1:0] gate,
    input logic             period_irq,
    input logic             pwm_sync,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] half_act
);
    logic [2*NPH-1:0] act;
    logic [NPH-1:0]   both;

    assign act = gate ^ {(2*NPH){~pol_hi}};

    // Pairs active at the same time
    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            both[i] = act[2*i] & act[2*i+1];
        end
    end

    // R13
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both == '0);

    // R9
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n |-> (gate == {(2*NPH){~pol_hi}}));

    // R1
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> !period_irq);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half_act);

    // R2
    sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_sync) |-> period_irq);

endmodule

bind tri_pwm_gen tri_pwm_chk #(
    .NPH   (NPH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_n     (trip_n),
    .pol_hi     (pol_hi),
    .gate       (gate),
    .period_irq (period_irq),
    .pwm_sync   (pwm_sync),
    .cnt        (cnt_w),
    .half_act   (half_act_w)
);

// File: tb/tri_pwm_gen_bench.sv
`timescale 1ns/1ps
// Directed bench for the three-phase PWM generator; one task per scenario.
module tri_pwm_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trip_n = 1'b1;
    logic        pol_hi = 1'b1;
    logic [5:0]  gate;
    logic        pwm_sync;
    logic        period_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int on_cnt [6];
    int sync_c, irq_c, shoot_c, low0_c;

    localparam int HALF = 20;
    localparam logic [15:0] EN_ALL = 16'h3F00;

    always #2.5 clk = ~clk;

    tri_pwm_gen u_tri_pwm_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .trip_n     (trip_n),
        .pol_hi     (pol_hi),
        .gate       (gate),
        .pwm_sync   (pwm_sync),
        .period_irq (period_irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!period_irq);
    endtask

    task automatic settle();
        wait_irq();
        wait_irq();
    endtask

    // Count active cycles of each gate and the flags over n cycles
    task automatic count_win(int n);
        logic [5:0] a;
        for (int k = 0; k < 6; k++) on_cnt[k] = 0;
        sync_c = 0; irq_c = 0; shoot_c = 0; low0_c = 0;
        for (int c = 0; c < n; c++) begin
            a = gate ^ {6{~pol_hi}};
            for (int k = 0; k < 6; k++) on_cnt[k] += int'(a[k]);
            sync_c  += int'(pwm_sync);
            irq_c   += int'(period_irq);
            low0_c  += int'(!gate[0]);
            for (int p = 0; p < 3; p++) shoot_c += int'(a[2*p] & a[2*p+1]);
            @(negedge clk);
        end
    endtask

    task automatic set_duties(int da, int db, int dc);
        wr(4'd1, 16'(da));
        wr(4'd2, 16'(db));
        wr(4'd3, 16'(dc));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 reset gates off", int'(gate), 0);
    endtask

    task automatic t_period();
        int gap;
        wr(4'd0, 16'(HALF));
        wr(4'd6, 16'd4);
        wr(4'd8, EN_ALL);
        set_duties(8, 4, 0);
        settle();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!period_irq);
        check("R1 irq spacing", gap, 2*HALF);
        count_win(2*HALF);
        check("R1 irq per period", irq_c, 1);
        check("R2 sync width", sync_c, 5);
        check("R3 A high", on_cnt[0], 16);
        check("R3 A low", on_cnt[1], 24);
        check("R3 B high", on_cnt[2], 8);
        check("R3 C high", on_cnt[4], 0);
        check("R3 C low", on_cnt[5], 40);
        check("R13 no overlap", shoot_c, 0);
    endtask

    task automatic t_update();
        int n;
        set_duties(4, 4, 4);
        settle();
        wait_irq();
        repeat (4) @(negedge clk);
        wr(4'd1, 16'd8);
        n = 0;
        while (!period_irq) begin n += int'(gate[0]); @(negedge clk); end
        check("R4 single update holds old duty", n, 8);
        wr(4'd1, 16'd4);
        wr(4'd8, EN_ALL | 16'h0001);
        settle();
        wait_irq();
        repeat (4) @(negedge clk);
        wr(4'd1, 16'd8);
        n = 0;
        while (!period_irq) begin n += int'(gate[0]); @(negedge clk); end
        check("R5 double update at midpoint", n, 12);
        wr(4'd8, EN_ALL);
    endtask

    task automatic t_dead();
        wr(4'd4, 16'd2);
        set_duties(8, 8, 8);
        settle();
        count_win(2*HALF);
        check("R6 dead high", on_cnt[0], 12);
        check("R6 dead low", on_cnt[1], 20);
        check("R13 no overlap with dead time", shoot_c, 0);
        wr(4'd4, 16'd0);
    endtask

    task automatic t_minpw();
        wr(4'd5, 16'd20);
        set_duties(8, 12, 10);
        settle();
        count_win(2*HALF);
        check("R7 narrow high deleted", on_cnt[0], 0);
        check("R7 narrow high low side", on_cnt[1], 40);
        check("R7 narrow low deleted", on_cnt[2], 40);
        check("R7 equal width kept", on_cnt[4], 20);
        wr(4'd5, 16'd0);
    endtask

    task automatic t_overmod();
        set_duties(25, 20, 8);
        settle();
        count_win(4*HALF);
        check("R8 overmod high", on_cnt[0], 80);
        check("R8 overmod low", on_cnt[1], 0);
        check("R8 duty equal half high", on_cnt[2], 80);
    endtask

    task automatic t_enable();
        wr(4'd8, 16'h3E00);
        set_duties(8, 8, 8);
        settle();
        count_win(2*HALF);
        check("R10 disabled AH", on_cnt[0], 0);
        check("R10 enabled AL", on_cnt[1], 24);
        wr(4'd8, EN_ALL);
    endtask

    task automatic t_pol();
        @(negedge clk);
        pol_hi = 1'b0;
        settle();
        count_win(2*HALF);
        check("R11 active-low AH low cycles", low0_c, 16);
        pol_hi = 1'b1;
    endtask

    task automatic t_chop();
        wr(4'd7, 16'd0);
        wr(4'd8, EN_ALL | 16'h0002);
        set_duties(25, 8, 8);
        settle();
        count_win(2*HALF);
        check("R12 chopped full high", on_cnt[0], 20);
        check("R12 chopped pulse high", on_cnt[2], 8);
        check("R12 low side unchopped", on_cnt[3], 24);
        wr(4'd7, 16'd1);
        settle();
        count_win(8*HALF);
        check("R12 divider one high", on_cnt[0], 80);
        wr(4'd8, EN_ALL);
    endtask

    task automatic t_trip();
        set_duties(8, 8, 8);
        settle();
        @(negedge clk);
        trip_n = 1'b0;
        #1;
        check("R9 trip forces off", int'(gate), 0);
        repeat (4) @(negedge clk);
        wr(4'd9, 16'd0);
        @(negedge clk);
        trip_n = 1'b1;
        repeat (3) @(negedge clk);
        count_win(2*HALF);
        check("R9 latched after release", on_cnt[0] + on_cnt[1], 0);
        wr(4'd9, 16'd0);
        settle();
        count_win(2*HALF);
        check("R9 resumes after clear", on_cnt[0], 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_period();
        t_update();
        t_dead();
        t_minpw();
        t_overmod();
        t_enable();
        t_pol();
        t_chop();
        t_trip();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule